// File: doc/BRIEF.md
# Randomized Root Contention Resolver

This block is the per-node controller that breaks a symmetric tie on a point-to-point link, where both ends have asked the other to become their parent. Each node backs off for either a short or a long interval, chosen by a pseudo-random bit. When the backoff ends, the node acts on the last symbol seen from its peer. If the peer was still requesting, the node acknowledges and becomes root. If the peer had gone idle, the node issues its own request and waits to be acknowledged, which makes it the child.

The node watches a two-bit received-symbol input. Each cycle it may place one symbol on a two-bit transmit output for a single cycle. Two status flags report the terminal outcome. The timer counts one unit per clock. A free-running 16-bit maximal-length LFSR supplies the speed choice, so the two speeds are equally likely. While waiting, the timer never counts past the upper edge of the chosen window. It also never exceeds 168.

States:
- `ST_CONTEND`: contention; entered at reset and on a request while in send-request or received-idle.
- `ST_RX_IDLE`: idle received during contention.
- `ST_WREQ_FAST` / `ST_WREQ_SLOW`: request-seen backoff.
- `ST_WIDLE_FAST` / `ST_WIDLE_SLOW`: idle-seen backoff.
- `ST_SEND_REQ`: own request sent.
- `ST_ROOT` / `ST_CHILD`: terminal.

Transitions:
- contention → received-idle on idle.
- contention → request-seen backoff, otherwise, with idle sent.
- received-idle → contention on request.
- received-idle → idle-seen backoff, otherwise, with idle sent.
- request-seen ↔ idle-seen, at the same speed, on idle or request respectively.
- request-seen → root when the timer is at or past the window minimum, with acknowledge sent.
- idle-seen → send-request under the same timer condition, with request sent.
- send-request → contention on request.
- send-request → child on acknowledge.

Top module: `rcr_node`

## Requirements
- R1: While reset is held and right after it is released, tx_sym is 2'b00 and is_root and is_child are low; the node is in contention.
- R2: In contention with a received symbol other than idle, the node sends idle (tx_sym 2'b11) after the next edge. It enters the request-seen backoff with its timer cleared. The speed is fast when bit 0 of the LFSR is 1 at that edge. The LFSR holds 16'hACE1 in reset, shifts left every cycle, and feeds back the XOR of bits 15, 13, 12 and 10 into bit 0.
- R3: Fast window. In request-seen backoff with no symbol received, acknowledge (2'b10) appears 77 cycles after the idle was sent (timer 76), together with is_root.
- R4: Slow window. The same as R3, with acknowledge appearing 160 cycles after the idle (timer 159).
- R5: In idle-seen backoff, request (2'b01) is sent once the timer reaches the window minimum, and the node enters send-request.
- R6: Idle (2'b11) received in request-seen backoff moves the node to idle-seen backoff at the same speed without clearing the timer.
- R7: Request (2'b01) received in idle-seen backoff moves the node to request-seen backoff at the same speed without clearing the timer.
- R8: In send-request, a received request returns the node to contention, and a received acknowledge (2'b10) makes it child.
- R9: Idle received in contention moves the node to received-idle with nothing sent. From there, a request returns it to contention; any other symbol makes it send idle and start the idle-seen backoff.
- R10: When a symbol that switches the backoff state arrives in the cycle the timer reaches the minimum, the switch wins and the send is not made in that cycle.
- R11: is_root and is_child are never both high. Each holds until reset, and received symbols then have no effect on either flag or on tx_sym.
- R12: tx_sym is 2'b00 except for single-cycle pulses that follow an action, never two in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one timer unit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_sym | input | 2 | Symbol from peer: 00 none, 01 request, 10 acknowledge, 11 idle |
| tx_sym | output | 2 | Symbol sent to peer, same encoding, registered |
| is_root | output | 1 | Node has become root |
| is_child | output | 1 | Node has become child |

## Verification
The timer-driven send at the window minimum and a state-switching received symbol can land on the same edge. The bench provokes this by delivering idle on exactly the edge where the request-seen backoff would acknowledge. It judges the result by the absence of acknowledge and root on that edge and a request one cycle later. A behavioural model with its own LFSR and timer is compared on every cycle. Its window and speed drive the expected cycle counts for both speeds.

// File: rtl/rcr_pkg.sv
package rcr_pkg;

    typedef enum logic [1:0] {
        SYM_NONE = 2'b00,
        SYM_REQ  = 2'b01,
        SYM_ACK  = 2'b10,
        SYM_IDLE = 2'b11
    } sym_t;

    typedef enum logic [3:0] {
        ST_CONTEND,
        ST_RX_IDLE,
        ST_WREQ_FAST,
        ST_WREQ_SLOW,
        ST_WIDLE_FAST,
        ST_WIDLE_SLOW,
        ST_SEND_REQ,
        ST_ROOT,
        ST_CHILD
    } state_t;

endpackage

// File: rtl/rcr_lfsr.sv
module rcr_lfsr #(
    parameter int          W    = 16,
    parameter logic [W-1:0] SEED = 16'hACE1,
    parameter logic [W-1:0] TAPS = 16'hB400
) (
    input  logic clk,
    input  logic rst_n,
    output logic coin
);
    logic [W-1:0] q;
    logic         fb;

    assign fb   = ^(q & TAPS);
    assign coin = q[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= SEED;
        else        q <= {q[W-2:0], fb};
    end
endmodule

// File: rtl/rcr_timer.sv
module rcr_timer #(
    parameter int SAT = 168,
    parameter int TW  = $clog2(SAT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          run,
    input  logic [TW-1:0] lim,
    output logic [TW-1:0] value
);
    localparam logic [TW-1:0] SAT_V = TW'(SAT);
    logic [TW-1:0] cap;

    assign cap = (lim > SAT_V) ? SAT_V : lim;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  value <= '0;
        else if (clr)                value <= '0;
        else if (run && value < cap) value <= value + 1'b1;
    end
endmodule

// File: rtl/rcr_fsm.sv
module rcr_fsm import rcr_pkg::*; #(
    parameter int FAST_MIN = 76,
    parameter int FAST_MAX = 85,
    parameter int SLOW_MIN = 159,
    parameter int SLOW_MAX = 167,
    parameter int TW       = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  sym_t          rx,
    input  logic          coin,
    input  logic [TW-1:0] tmr,
    output logic          tmr_clr,
    output logic          tmr_run,
    output logic [TW-1:0] tmr_lim,
    output sym_t          tx,
    output state_t        state
);
    localparam logic [TW-1:0] FMIN_V = TW'(FAST_MIN);
    localparam logic [TW-1:0] FMAX_V = TW'(FAST_MAX);
    localparam logic [TW-1:0] SMIN_V = TW'(SLOW_MIN);
    localparam logic [TW-1:0] SMAX_V = TW'(SLOW_MAX);

    state_t        nxt;
    sym_t          tx_nxt;
    logic          slow;
    logic          due;
    logic [TW-1:0] wmin;

    assign slow    = (state == ST_WREQ_SLOW) || (state == ST_WIDLE_SLOW);
    assign wmin    = slow ? SMIN_V : FMIN_V;
    assign tmr_lim = slow ? SMAX_V : FMAX_V;
    assign due     = (tmr >= wmin);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_CONTEND;
        else        state <= nxt;
    end

    // next-state and action decode
    always_comb begin
        nxt     = state;
        tx_nxt  = SYM_NONE;
        tmr_clr = 1'b0;
        tmr_run = 1'b0;
        unique case (state)
            ST_CONTEND: begin
                if (rx == SYM_IDLE) begin
                    nxt = ST_RX_IDLE;
                end else begin
                    tx_nxt  = SYM_IDLE;
                    tmr_clr = 1'b1;
                    nxt     = coin ? ST_WREQ_FAST : ST_WREQ_SLOW;
                end
            end
            ST_RX_IDLE: begin
                if (rx == SYM_REQ) begin
                    nxt = ST_CONTEND;
                end else begin
                    tx_nxt  = SYM_IDLE;
                    tmr_clr = 1'b1;
                    nxt     = coin ? ST_WIDLE_FAST : ST_WIDLE_SLOW;
                end
            end
            ST_WREQ_FAST, ST_WREQ_SLOW: begin
                if (rx == SYM_IDLE) begin
                    tmr_run = 1'b1;
                    nxt     = slow ? ST_WIDLE_SLOW : ST_WIDLE_FAST;
                end else if (due) begin
                    tx_nxt = SYM_ACK;
                    nxt    = ST_ROOT;
                end else begin
                    tmr_run = 1'b1;
                end
            end
            ST_WIDLE_FAST, ST_WIDLE_SLOW: begin
                if (rx == SYM_REQ) begin
                    tmr_run = 1'b1;
                    nxt     = slow ? ST_WREQ_SLOW : ST_WREQ_FAST;
                end else if (due) begin
                    tx_nxt = SYM_REQ;
                    nxt    = ST_SEND_REQ;
                end else begin
                    tmr_run = 1'b1;
                end
            end
            ST_SEND_REQ: begin
                if (rx == SYM_REQ)      nxt = ST_CONTEND;
                else if (rx == SYM_ACK) nxt = ST_CHILD;
            end
            ST_ROOT:  nxt = ST_ROOT;
            ST_CHILD: nxt = ST_CHILD;
            default:  nxt = ST_CONTEND;
        endcase
    end

    // registered output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx <= SYM_NONE;
        else        tx <= tx_nxt;
    end
endmodule

// File: rtl/rcr_node.sv
module rcr_node import rcr_pkg::*; #(
    parameter int          FAST_MIN = 76,
    parameter int          FAST_MAX = 85,
    parameter int          SLOW_MIN = 159,
    parameter int          SLOW_MAX = 167,
    parameter int          TMR_SAT  = 168,
    parameter int          RNG_W    = 16,
    parameter logic [15:0] RNG_SEED = 16'hACE1,
    parameter logic [15:0] RNG_TAPS = 16'hB400
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] rx_sym,
    output logic [1:0] tx_sym,
    output logic       is_root,
    output logic       is_child
);
    localparam int TW = $clog2(TMR_SAT + 1);

    sym_t          rx_t;
    sym_t          tx_t;
    state_t        state;
    logic          coin;
    logic          tmr_clr;
    logic          tmr_run;
    logic [TW-1:0] tmr_lim;
    logic [TW-1:0] tmr;

    assign rx_t     = sym_t'(rx_sym);
    assign tx_sym   = tx_t;
    assign is_root  = (state == ST_ROOT);
    assign is_child = (state == ST_CHILD);

    rcr_lfsr #(
        .W    (RNG_W),
        .SEED (RNG_W'(RNG_SEED)),
        .TAPS (RNG_W'(RNG_TAPS))
    ) u_lfsr (
        .clk  (clk),
        .rst_n(rst_n),
        .coin (coin)
    );

    rcr_timer #(
        .SAT(TMR_SAT),
        .TW (TW)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (tmr_clr),
        .run  (tmr_run),
        .lim  (tmr_lim),
        .value(tmr)
    );

    rcr_fsm #(
        .FAST_MIN(FAST_MIN),
        .FAST_MAX(FAST_MAX),
        .SLOW_MIN(SLOW_MIN),
        .SLOW_MAX(SLOW_MAX),
        .TW      (TW)
    ) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .rx     (rx_t),
        .coin   (coin),
        .tmr    (tmr),
        .tmr_clr(tmr_clr),
        .tmr_run(tmr_run),
        .tmr_lim(tmr_lim),
        .tx     (tx_t),
        .state  (state)
    );
endmodule

// File: rtl/rcr_node_chk.sv
module rcr_node_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] rx_sym,
    input logic [1:0] tx_sym,
    input logic       is_root,
    input logic       is_child
);
    localparam logic [1:0] K_NONE = 2'b00;
    localparam logic [1:0] K_ACK  = 2'b10;

    // R11
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(is_root && is_child));

    // R11
    root_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_root |=> is_root);

    // R11
    child_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_child |=> is_child);

    // R12
    tx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_sym != K_NONE) |=> (tx_sym == K_NONE));

    // R3
    root_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(is_root) |-> (tx_sym == K_ACK));

    // R8
    child_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(is_child) |-> ($past(rx_sym) == K_ACK));
endmodule

bind rcr_node rcr_node_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_sym  (rx_sym),
    .tx_sym  (tx_sym),
    .is_root (is_root),
    .is_child(is_child)
);

// File: tb/rcr_node_test.sv
`timescale 1ns/1ps
module rcr_node_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] rx_sym = 2'b00;
    logic [1:0] tx_sym;
    logic       is_root;
    logic       is_child;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rcr_node uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_sym  (rx_sym),
        .tx_sym  (tx_sym),
        .is_root (is_root),
        .is_child(is_child)
    );

    // behavioural reference model
    localparam int M_CON = 0, M_RXI = 1, M_WREQ = 2, M_WIDLE = 3,
                   M_SREQ = 4, M_ROOT = 5, M_CHILD = 6;
    int          ms;
    int          mt;
    bit          m_fast;
    logic [15:0] m_rng;
    logic [1:0]  m_tx;

    function automatic int wmin(bit f); return f ? 76 : 159; endfunction
    function automatic int wmax(bit f); return f ? 85 : 167; endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            ms = M_CON; mt = 0; m_fast = 1'b0; m_rng = 16'hACE1; m_tx = 2'b00;
        end else begin
            logic [1:0] t;
            bit c;
            t = 2'b00;
            c = m_rng[0];
            case (ms)
                M_CON:  if (rx_sym == 2'b11) ms = M_RXI;
                        else begin t = 2'b11; mt = 0; m_fast = c; ms = M_WREQ; end
                M_RXI:  if (rx_sym == 2'b01) ms = M_CON;
                        else begin t = 2'b11; mt = 0; m_fast = c; ms = M_WIDLE; end
                M_WREQ: if (rx_sym == 2'b11) begin ms = M_WIDLE; mt = (mt < wmax(m_fast)) ? mt + 1 : mt; end
                        else if (mt >= wmin(m_fast)) begin t = 2'b10; ms = M_ROOT; end
                        else mt = (mt < wmax(m_fast)) ? mt + 1 : mt;
                M_WIDLE: if (rx_sym == 2'b01) begin ms = M_WREQ; mt = (mt < wmax(m_fast)) ? mt + 1 : mt; end
                        else if (mt >= wmin(m_fast)) begin t = 2'b01; ms = M_SREQ; end
                        else mt = (mt < wmax(m_fast)) ? mt + 1 : mt;
                M_SREQ: if (rx_sym == 2'b01) ms = M_CON;
                        else if (rx_sym == 2'b10) ms = M_CHILD;
                default: ;
            endcase
            m_rng = {m_rng[14:0], m_rng[15] ^ m_rng[13] ^ m_rng[12] ^ m_rng[10]};
            m_tx = t;
        end
    end

    // cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (tx_sym !== m_tx) begin
                errors++;
                $display("FAIL R12 model tx actual=%0d expected=%0d", tx_sym, m_tx);
            end
            checks++;
            if (is_root !== (ms == M_ROOT) || is_child !== (ms == M_CHILD)) begin
                errors++;
                $display("FAIL R11 model flags actual=%0d%0d expected=%0d%0d",
                         is_root, is_child, ms == M_ROOT, ms == M_CHILD);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input logic [1:0] s);
        @(posedge clk);
        #1;
        rx_sym = s;
    endtask

    task automatic do_reset(input logic [1:0] first);
        rst_n  = 1'b0;
        rx_sym = 2'b00;
        tick(2'b00);
        tick(2'b00);
        @(posedge clk);
        #1;
        rst_n  = 1'b1;
        rx_sym = first;
    endtask

    task automatic wait_tx(input int lim, output int n);
        n = 0;
        do begin
            tick(2'b00);
            n++;
        end while (tx_sym == 2'b00 && n < lim);
    endtask

    task automatic hold_terminal(input bit root);
        for (int i = 0; i < 20; i++) begin
            tick(2'($urandom_range(0, 3)));
            chk(is_root == root && is_child == !root && tx_sym == 2'b00,
                "R11 terminal hold", {is_root, is_child, tx_sym}, root ? 8 : 4);
        end
    endtask

    initial begin
        int n;
        int m;
        int fast_seen;
        int slow_seen;

        // R1 reset state
        do_reset(2'b00);
        chk(tx_sym == 2'b00 && !is_root && !is_child, "R1 reset",
            {is_root, is_child, tx_sym}, 0);

        // R2 idle sent after first edge; R3/R4 acknowledge timing
        tick(2'b00);
        chk(tx_sym == 2'b11, "R2 idle sent", tx_sym, 3);
        m = wmin(m_fast);
        wait_tx(400, n);
        chk(tx_sym == 2'b10 && n == m + 1, m_fast ? "R3 fast ack" : "R4 slow ack", n, m + 1);
        chk(is_root, "R3 root flag", is_root, 1);
        tick(2'b00);
        chk(tx_sym == 2'b00, "R12 pulse ends", tx_sym, 0);
        hold_terminal(1'b1);

        // R2 speed selection across LFSR phases, R3 and R4 windows
        fast_seen = 0;
        slow_seen = 0;
        for (int d = 0; d < 12; d++) begin
            do_reset(2'b11);
            for (int i = 0; i < d; i++) begin
                tick(2'b01);
                tick(2'b11);
            end
            tick(2'b01);
            tick(2'b00);
            tick(2'b00);
            chk(tx_sym == 2'b11, "R2 idle after dwell", tx_sym, 3);
            m = wmin(m_fast);
            if (m_fast) fast_seen++; else slow_seen++;
            wait_tx(400, n);
            chk(tx_sym == 2'b10 && n == m + 1, m_fast ? "R3 fast ack" : "R4 slow ack", n, m + 1);
        end
        chk(fast_seen > 0 && slow_seen > 0, "R2 both speeds", fast_seen * 100 + slow_seen, 1);

        // R6 idle in request-seen wait keeps timer; R8 child on acknowledge
        do_reset(2'b00);
        tick(2'b00);
        m = wmin(m_fast);
        n = 0;
        do begin
            n++;
            tick(n == 30 ? 2'b11 : 2'b00);
        end while (tx_sym == 2'b00 && n < 400);
        chk(tx_sym == 2'b01 && n == m + 1, "R6 request after switch", n, m + 1);
        tick(2'b10);
        tick(2'b00);
        chk(is_child && !is_root, "R8 child", is_child, 1);
        hold_terminal(1'b0);

        // R10 idle arrives on the edge the acknowledge would be sent
        do_reset(2'b00);
        tick(2'b00);
        m = wmin(m_fast);
        for (int k = 1; k <= m; k++) tick(k == m ? 2'b11 : 2'b00);
        tick(2'b00);
        chk(tx_sym == 2'b00 && !is_root, "R10 switch wins", tx_sym, 0);
        tick(2'b00);
        chk(tx_sym == 2'b01, "R10 request next", tx_sym, 1);
        tick(2'b01);
        tick(2'b00);
        chk(tx_sym == 2'b00 && !is_child, "R8 back to contention", tx_sym, 0);
        tick(2'b00);
        chk(tx_sym == 2'b11, "R8 contention resends idle", tx_sym, 3);

        // R9 idle in contention; R5 request from idle-seen wait
        do_reset(2'b11);
        tick(2'b00);
        chk(tx_sym == 2'b00, "R9 received idle silent", tx_sym, 0);
        tick(2'b00);
        chk(tx_sym == 2'b11, "R9 idle sent from received-idle", tx_sym, 3);
        m = wmin(m_fast);
        wait_tx(400, n);
        chk(tx_sym == 2'b01 && n == m + 1, "R5 request at minimum", n, m + 1);
        tick(2'b01);
        tick(2'b00);
        chk(tx_sym == 2'b00, "R8 request in send-request", tx_sym, 0);
        tick(2'b00);
        chk(tx_sym == 2'b11, "R8 contention again", tx_sym, 3);

        // R7 request in idle-seen wait
        do_reset(2'b11);
        tick(2'b00);
        tick(2'b00);
        m = wmin(m_fast);
        n = 0;
        do begin
            n++;
            tick(n == 10 ? 2'b01 : 2'b00);
        end while (tx_sym == 2'b00 && n < 400);
        chk(tx_sym == 2'b10 && n == m + 1, "R7 ack after switch", n, m + 1);

        // R9 request in received-idle returns to contention
        do_reset(2'b11);
        tick(2'b01);
        tick(2'b00);
        chk(tx_sym == 2'b00, "R9 back to contention", tx_sym, 0);
        tick(2'b00);
        chk(tx_sym == 2'b11, "R9 contention sends idle", tx_sym, 3);
        wait_tx(400, n);
        chk(tx_sym == 2'b10, "R9 request-seen path", tx_sym, 2);

        // sparse random traffic against the model
        for (int r = 0; r < 30; r++) begin
            do_reset(2'b00);
            for (int i = 0; i < 400; i++)
                tick(($urandom_range(0, 9) < 7) ? 2'b00 : 2'($urandom_range(1, 3)));
        end

        tick(2'b00);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule